// File: doc/BRIEF.md
# Bus Fault Injector

This block sits in series on a parallel data bus. It changes the data passing through it so that logical faults can be emulated, which lets test and diagnosis logic further down the bus be exercised against known defects. The data path is purely combinational: `bus_out` follows `bus_in` in the same cycle. The fault configuration is held in registers that load from a configuration port when a write strobe is asserted.

The block can force any line to a fixed value. It can force the whole bus to a single value. It can also short a pair of lines together, and the short resolves as a wired-AND, a wired-OR or an unknown value. Forcing is applied first. The short then resolves the two lines from their values after forcing. A status output is high whenever any fault setting is enabled.

Top module: `bus_fault_injector`

## Requirements
- R1: While `rst` is high at a rising clock edge, every fault setting clears. After that edge, `bus_out` equals `bus_in` and `fault_active` is 0.
- R2: All configuration inputs load at a rising edge when `cfg_we` is 1. When `cfg_we` is 0, changes on the configuration inputs have no effect on `bus_out` or `fault_active`.
- R3: A line whose force-enable bit is 0 passes its `bus_in` bit. A line whose force-enable bit is 1 outputs its force-value bit.
- R4: When whole-bus forcing is enabled (`cfg_all_en`=1), every line before bridging takes `cfg_all_val`. This overrides the per-line settings.
- R5: Bridge kind code 2'b01 is a wired-AND. Both bridged lines output the AND of their two values after forcing.
- R6: Bridge kind code 2'b10 is a wired-OR. Both bridged lines output the OR of their two values after forcing.
- R7: Bridge kind code 2'b11 is an indeterminate short. Both bridged lines are driven to X, and every other line is unaffected.
- R8: No bridge is applied when the bridge enable is 0, when the kind code is 2'b00, or when both line indices are equal.
- R9: A bridge resolves from the values after forcing, so a line forced to 1 under a wired-OR pulls its partner to 1, and a line forced to 0 under a wired-AND pulls its partner to 0.
- R10: `fault_active` is 1 exactly when any force-enable bit is set, whole-bus forcing is enabled, or the bridge is enabled with a kind code other than 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for all configuration registers |
| cfg_force_en | input | WIDTH | Per-line force enable |
| cfg_force_val | input | WIDTH | Per-line forced value |
| cfg_all_en | input | 1 | Whole-bus force enable |
| cfg_all_val | input | 1 | Whole-bus forced value |
| cfg_br_en | input | 1 | Bridge enable |
| cfg_br_kind | input | 2 | Bridge kind: 00 none, 01 AND, 10 OR, 11 unknown |
| cfg_br_a | input | IDX_W | First bridged line index |
| cfg_br_b | input | IDX_W | Second bridged line index |
| bus_in | input | WIDTH | Fault-free bus data |
| bus_out | output | WIDTH | Bus data with faults applied |
| fault_active | output | 1 | Any fault setting enabled |

## Verification
The assertions assume that both bridge indices are below WIDTH and that the configuration inputs are stable around the clock edge. They also assume that the outputs are compared only on lines that are not driven to X. The bench drives every input just after a falling edge and only uses indices inside the bus. Under the indeterminate bridge it masks the two shorted lines out of its comparison, and it still checks every other line bit for bit.

// File: rtl/bfi_pkg.sv
package bfi_pkg;

    localparam int BR_IDX_W = 8;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_AND  = 2'b01,
        BR_OR   = 2'b10,
        BR_UNK  = 2'b11
    } bridge_kind_e;

    typedef struct packed {
        logic                en;
        bridge_kind_e        kind;
        logic [BR_IDX_W-1:0] a;
        logic [BR_IDX_W-1:0] b;
    } bridge_cfg_t;

    function automatic logic resolve_short(bridge_kind_e kind, logic x, logic y);
        case (kind)
            BR_AND:  return x & y;
            BR_OR:   return x | y;
            BR_UNK:  return 1'bx;
            default: return x;
        endcase
    endfunction

    function automatic logic bridge_live(bridge_cfg_t br);
        return br.en && (br.kind != BR_NONE) && (br.a != br.b);
    endfunction

endpackage

// File: rtl/bfi_cfg_regs.sv
module bfi_cfg_regs
    import bfi_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] force_en_d,
    input  logic [WIDTH-1:0] force_val_d,
    input  logic             all_en_d,
    input  logic             all_val_d,
    input  logic             br_en_d,
    input  logic [1:0]       br_kind_d,
    input  logic [IDX_W-1:0] br_a_d,
    input  logic [IDX_W-1:0] br_b_d,
    output logic [WIDTH-1:0] force_en_q,
    output logic [WIDTH-1:0] force_val_q,
    output logic             all_en_q,
    output logic             all_val_q,
    output bridge_cfg_t      br_q
);

    bridge_cfg_t br_d;

    always_comb begin
        br_d      = '0;
        br_d.en   = br_en_d;
        br_d.kind = bridge_kind_e'(br_kind_d);
        br_d.a    = BR_IDX_W'(br_a_d);
        br_d.b    = BR_IDX_W'(br_b_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_en_q  <= '0;
            force_val_q <= '0;
            all_en_q    <= 1'b0;
            all_val_q   <= 1'b0;
            br_q        <= '0;
        end else if (we) begin
            force_en_q  <= force_en_d;
            force_val_q <= force_val_d;
            all_en_q    <= all_en_d;
            all_val_q   <= all_val_d;
            br_q        <= br_d;
        end
    end

endmodule

// File: rtl/bfi_force_stage.sv
module bfi_force_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] force_en,
    input  logic [WIDTH-1:0] force_val,
    input  logic             all_en,
    input  logic             all_val,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_comb begin
            if (all_en)
                dout[i] = all_val;
            else if (force_en[i])
                dout[i] = force_val[i];
            else
                dout[i] = din[i];
        end
    end

endmodule

// File: rtl/bfi_bridge_stage.sv
module bfi_bridge_stage
    import bfi_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] din,
    input  bridge_cfg_t      br,
    output logic [WIDTH-1:0] dout
);

    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic             live;
    logic             shorted;

    assign idx_a   = br.a[IDX_W-1:0];
    assign idx_b   = br.b[IDX_W-1:0];
    assign live    = bridge_live(br);
    assign shorted = resolve_short(br.kind, din[idx_a], din[idx_b]);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic hit;
        assign hit     = live && ((br.a == BR_IDX_W'(i)) || (br.b == BR_IDX_W'(i)));
        assign dout[i] = hit ? shorted : din[i];
    end

endmodule

// File: rtl/bus_fault_injector.sv
module bus_fault_injector
    import bfi_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [WIDTH-1:0] cfg_force_en,
    input  logic [WIDTH-1:0] cfg_force_val,
    input  logic             cfg_all_en,
    input  logic             cfg_all_val,
    input  logic             cfg_br_en,
    input  logic [1:0]       cfg_br_kind,
    input  logic [IDX_W-1:0] cfg_br_a,
    input  logic [IDX_W-1:0] cfg_br_b,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             fault_active
);

    logic [WIDTH-1:0] force_en_q;
    logic [WIDTH-1:0] force_val_q;
    logic             all_en_q;
    logic             all_val_q;
    bridge_cfg_t      br_q;
    logic [WIDTH-1:0] forced;

    logic             br_en_q;
    logic [1:0]       br_kind_q;
    logic [IDX_W-1:0] br_a_q;
    logic [IDX_W-1:0] br_b_q;

    assign br_en_q   = br_q.en;
    assign br_kind_q = br_q.kind;
    assign br_a_q    = br_q.a[IDX_W-1:0];
    assign br_b_q    = br_q.b[IDX_W-1:0];

    bfi_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .force_en_d  (cfg_force_en),
        .force_val_d (cfg_force_val),
        .all_en_d    (cfg_all_en),
        .all_val_d   (cfg_all_val),
        .br_en_d     (cfg_br_en),
        .br_kind_d   (cfg_br_kind),
        .br_a_d      (cfg_br_a),
        .br_b_d      (cfg_br_b),
        .force_en_q  (force_en_q),
        .force_val_q (force_val_q),
        .all_en_q    (all_en_q),
        .all_val_q   (all_val_q),
        .br_q        (br_q)
    );

    bfi_force_stage #(.WIDTH(WIDTH)) u_force (
        .din       (bus_in),
        .force_en  (force_en_q),
        .force_val (force_val_q),
        .all_en    (all_en_q),
        .all_val   (all_val_q),
        .dout      (forced)
    );

    bfi_bridge_stage #(.WIDTH(WIDTH)) u_bridge (
        .din  (forced),
        .br   (br_q),
        .dout (bus_out)
    );

    assign fault_active = (|force_en_q) || all_en_q || (br_q.en && (br_q.kind != BR_NONE));

endmodule

// File: rtl/bfi_checker.sv
module bfi_checker #(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [WIDTH-1:0] cfg_force_en,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             fault_active,
    input logic [WIDTH-1:0] force_en_q,
    input logic             all_en_q,
    input logic             all_val_q,
    input logic             br_en_q,
    input logic [1:0]       br_kind_q,
    input logic [IDX_W-1:0] br_a_q,
    input logic [IDX_W-1:0] br_b_q
);

    logic br_live;
    assign br_live = br_en_q && (br_kind_q != 2'b00) && (br_a_q != br_b_q);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!fault_active && (bus_out == bus_in)));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (force_en_q == $past(cfg_force_en)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(force_en_q));

    p_whole_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (all_en_q && !br_live) |-> (bus_out == {WIDTH{all_val_q}}));

    p_and_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (br_live && br_kind_q == 2'b01) |-> (bus_out[br_a_q] == bus_out[br_b_q]));

    p_or_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (br_live && br_kind_q == 2'b10) |-> (bus_out[br_a_q] == bus_out[br_b_q]));

    p_quiet_pass_r10: assert property (@(posedge clk) disable iff (rst)
        !fault_active |-> (bus_out == bus_in));

    p_status_force_r10: assert property (@(posedge clk) disable iff (rst)
        (|force_en_q) |-> fault_active);

endmodule

bind bus_fault_injector bfi_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_force_en (cfg_force_en),
    .bus_in       (bus_in),
    .bus_out      (bus_out),
    .fault_active (fault_active),
    .force_en_q   (force_en_q),
    .all_en_q     (all_en_q),
    .all_val_q    (all_val_q),
    .br_en_q      (br_en_q),
    .br_kind_q    (br_kind_q),
    .br_a_q       (br_a_q),
    .br_b_q       (br_b_q)
);

// File: tb/bus_fault_injector_tb.sv
module bus_fault_injector_tb;

    localparam int W  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [W-1:0]  cfg_force_en = '0;
    logic [W-1:0]  cfg_force_val = '0;
    logic          cfg_all_en = 1'b0;
    logic          cfg_all_val = 1'b0;
    logic          cfg_br_en = 1'b0;
    logic [1:0]    cfg_br_kind = 2'b00;
    logic [IW-1:0] cfg_br_a = '0;
    logic [IW-1:0] cfg_br_b = '0;
    logic [W-1:0]  bus_in = '0;
    logic [W-1:0]  bus_out;
    logic          fault_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    logic [W-1:0] m_fen = '0, m_fval = '0;
    logic         m_aen = 0, m_aval = 0, m_ben = 0;
    int           m_kind = 0, m_a = 0, m_b = 0;

    always #10 clk = ~clk;

    bus_fault_injector #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_force_en(cfg_force_en), .cfg_force_val(cfg_force_val),
        .cfg_all_en(cfg_all_en), .cfg_all_val(cfg_all_val),
        .cfg_br_en(cfg_br_en), .cfg_br_kind(cfg_br_kind),
        .cfg_br_a(cfg_br_a), .cfg_br_b(cfg_br_b),
        .bus_in(bus_in), .bus_out(bus_out), .fault_active(fault_active)
    );

    function automatic logic bridge_on();
        return m_ben && m_kind != 0 && m_a != m_b;
    endfunction

    function automatic logic [W-1:0] model_out(logic [W-1:0] din);
        logic [W-1:0] v;
        logic r;
        for (int i = 0; i < W; i++)
            v[i] = m_aen ? m_aval : (m_fen[i] ? m_fval[i] : din[i]);
        if (bridge_on() && m_kind != 3) begin
            r = (m_kind == 1) ? (v[m_a] & v[m_b]) : (v[m_a] | v[m_b]);
            v[m_a] = r;
            v[m_b] = r;
        end
        return v;
    endfunction

    function automatic logic [W-1:0] model_mask();
        logic [W-1:0] mk = '0;
        if (bridge_on() && m_kind == 3) begin
            mk[m_a] = 1'b1;
            mk[m_b] = 1'b1;
        end
        return mk;
    endfunction

    task automatic check(input string tag);
        logic [W-1:0] e, mk;
        logic es;
        e  = model_out(bus_in);
        mk = model_mask();
        es = (|m_fen) || m_aen || (m_ben && m_kind != 0);
        checks++;
        if ((bus_out & ~mk) !== (e & ~mk)) begin
            errors++;
            $display("FAIL %s bus_out actual=%h expected=%h mask=%h", tag, bus_out, e, mk);
        end
        checks++;
        if (fault_active !== es) begin
            errors++;
            $display("FAIL R10 (%s) fault_active actual=%b expected=%b", tag, fault_active, es);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        if (rst) begin
            m_fen = '0; m_fval = '0; m_aen = 0; m_aval = 0;
            m_ben = 0; m_kind = 0; m_a = 0; m_b = 0;
        end else if (cfg_we) begin
            m_fen = cfg_force_en; m_fval = cfg_force_val;
            m_aen = cfg_all_en; m_aval = cfg_all_val; m_ben = cfg_br_en;
            m_kind = int'(cfg_br_kind); m_a = int'(cfg_br_a); m_b = int'(cfg_br_b);
        end
        @(negedge clk);
        if (!rst) check(tag);
        bus_in = W'($urandom);
    endtask

    task automatic wr(input logic [W-1:0] fen, input logic [W-1:0] fval,
                      input logic aen, input logic aval, input logic ben,
                      input logic [1:0] kind, input int a, input int b,
                      input string tag);
        cfg_force_en = fen; cfg_force_val = fval;
        cfg_all_en = aen; cfg_all_val = aval; cfg_br_en = ben;
        cfg_br_kind = kind; cfg_br_a = IW'(a); cfg_br_b = IW'(b);
        cfg_we = 1'b1;
        step(tag);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset clears even with a write strobe pending
        cfg_force_en = '1; cfg_all_en = 1'b1; cfg_we = 1'b1;
        run(3, "R1");
        cfg_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        run(4, "R1");
        // R2: config inputs changed without strobe have no effect
        cfg_force_en = '1; cfg_force_val = 16'hA5A5; cfg_all_en = 1'b1;
        cfg_br_en = 1'b1; cfg_br_kind = 2'b10; cfg_br_a = 4'd1; cfg_br_b = 4'd2;
        run(6, "R2");
        // R3: per-line forcing
        wr(16'hF00F, 16'h3005, 0, 0, 0, 2'b00, 0, 0, "R3");
        run(10, "R3");
        wr(16'h0001, 16'h0001, 0, 0, 0, 2'b00, 0, 0, "R3");
        run(5, "R3");
        // R4: whole-bus forcing over per-line settings
        wr(16'h00FF, 16'h0000, 1, 1, 0, 2'b00, 0, 0, "R4");
        run(5, "R4");
        wr(16'hFF00, 16'hFF00, 1, 0, 0, 2'b00, 0, 0, "R4");
        run(5, "R4");
        // R5: wired-AND bridge
        wr('0, '0, 0, 0, 1, 2'b01, 3, 9, "R5");
        run(12, "R5");
        // R6: wired-OR bridge on the edge lines
        wr('0, '0, 0, 0, 1, 2'b10, 0, 15, "R6");
        run(12, "R6");
        // R9: bridge resolves forced values
        wr(16'h0008, 16'h0008, 0, 0, 1, 2'b10, 3, 5, "R9");
        run(6, "R9");
        wr(16'h0020, 16'h0000, 0, 0, 1, 2'b01, 3, 5, "R9");
        run(6, "R9");
        // R7: indeterminate bridge leaves other lines intact
        wr(16'h0100, 16'h0100, 0, 0, 1, 2'b11, 4, 12, "R7");
        run(8, "R7");
        // R8: no bridge cases
        wr('0, '0, 0, 0, 1, 2'b00, 2, 7, "R8");
        run(5, "R8");
        wr('0, '0, 0, 0, 0, 2'b10, 2, 7, "R8");
        run(5, "R8");
        wr(16'h0040, 16'h0000, 0, 0, 1, 2'b01, 6, 6, "R8");
        run(5, "R8");
        // mixed random configurations
        for (int k = 0; k < 60; k++) begin
            wr(W'($urandom) & W'($urandom), W'($urandom), ($urandom % 8) == 0,
               1'($urandom), 1'($urandom), 2'($urandom),
               int'($urandom % W), int'($urandom % W), "R3");
            run(4, "R3");
        end
        // R1: reset again from a faulted state
        wr('1, '1, 1, 1, 1, 2'b10, 1, 2, "R4");
        rst = 1'b1;
        run(2, "R1");
        @(negedge clk);
        rst = 1'b0;
        run(4, "R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule